// File: doc/BRIEF.md
# Program Counter Sequencer with Two-Level Return Stack

This block produces the instruction fetch address for a small 4-bit controller whose program store holds 512 bytes. It tracks a 9-bit program counter and decodes the control-flow opcodes: jumps, subroutine calls, returns and table-driven jumps. Program memory is divided into 64-byte pages numbered by the top three counter bits. The same single-byte jump opcode has a wider reach when the counter sits in pages 2 or 3.

Each cycle the environment presents the byte stored at `fetch_addr` on `instr`. The block updates the counter from that byte, the accumulator nibble `acc` and the memory nibble `mnib`. A call saves its return address in a fixed two-entry stack, and the older entry is lost on overflow. One return variant also marks the next instruction for skipping. A skipped instruction is still fetched, and `skip_active` is high while it is discarded. The arithmetic unit and the data memory sit outside this block.

Top module: `pcs_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and both stack entries become 0x000 and the skip flag is cleared, so `fetch_addr` is 0x000 and `skip_active` is 0 afterwards.
- R2: Byte 0x60 or 0x61 followed by a second byte B is a long jump. One cycle after the second byte, `fetch_addr` is {first byte bit 0, B}.
- R3: In pages 2 and 3 (counter bits 8..6 equal to 010 or 011), any byte from 0x80 to 0xFE except 0xBF keeps counter bits 8..7 and loads counter bits 6..0 from byte bits 6..0.
- R4: In all other pages, a byte from 0xC0 to 0xFE keeps counter bits 8..6 and loads counter bits 5..0 from byte bits 5..0.
- R5: In all other pages, a byte from 0x80 to 0xBE is a short call. It moves the top stack entry into the lower entry, stores counter+1 in the top entry, and sets the counter to {010, byte bits 5..0}.
- R6: Byte 0x68 or 0x69 followed by B is a long call. It sets the counter to {first byte bit 0, B}, stores the address after B in the top stack entry, and moves the old top entry down.
- R7: Byte 0x48 loads the counter from the top stack entry and copies the lower entry into the top. The lower entry keeps its value.
- R8: Byte 0x49 performs the R7 return and then marks the instruction at the return address for skipping.
- R9: Byte 0xFF is a table jump. On the next cycle `fetch_addr` is {counter bit 8, `acc`, `mnib`}. The byte read there replaces counter bits 7..0 on the cycle after that, and is not decoded as an opcode.
- R10: A skipped instruction holds `skip_active` high for each of its bytes and advances the counter by one per byte. It has no effect on the counter or the stack otherwise. Bytes 0x23, 0x33 and 0x60 to 0x6F are two-byte instructions.
- R11: Every other byte, including 0xBF, advances the counter by one. The counter wraps from 0x1FF to 0x000.
- R12: The second byte of a two-byte instruction is never decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 8 | Program byte read at `fetch_addr` in this cycle |
| acc | input | 4 | Accumulator nibble, used for the table jump |
| mnib | input | 4 | Memory nibble, used for the table jump |
| fetch_addr | output | 9 | Program memory address to read |
| skip_active | output | 1 | The byte at `fetch_addr` belongs to a skipped instruction |

## Verification
Two functions can act in the same cycle: a pending skip from the return-then-skip opcode, and a control-flow opcode arriving at the return address. The bench places a short call, a within-page jump and a two-byte prefix right after a return-then-skip. It then judges the skip by the next address (counter+1 or +2) and by a later plain return, which shows whether the skipped call disturbed the stack. A prefix whose second byte equals the return opcode shows that second bytes are not decoded.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int PC_W   = 9;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int OFS_W  = 6;
    localparam int PG_W   = PC_W - OFS_W;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_OPER,
        ST_LOOKUP
    } seq_st_e;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_JUMP,
        LK_CALL
    } long_e;

    typedef enum logic [3:0] {
        OK_STEP,
        OK_PFX_JMP,
        OK_PFX_CALL,
        OK_PFX_OTHER,
        OK_RET,
        OK_RETSK,
        OK_JID,
        OK_JP_WIDE,
        OK_JP_PAGE,
        OK_JSRP
    } op_kind_e;

    typedef struct packed {
        long_e kind;
        logic  hi;
    } pend_t;

    localparam byte_t OP_RET   = 8'h48;
    localparam byte_t OP_RETSK = 8'h49;
    localparam byte_t OP_JID   = 8'hFF;
    localparam byte_t OP_LQ    = 8'hBF;
    localparam logic [PG_W-1:0] CALL_PAGE = 3'b010;

    function automatic logic is_two_byte(byte_t b);
        return (b == 8'h23) || (b == 8'h33) || (b[7:4] == 4'h6);
    endfunction

    function automatic logic page_is_wide(pc_t pc);
        return pc[PC_W-1:PC_W-2] == 2'b01;
    endfunction

    function automatic pc_t inc9(pc_t pc);
        return pc + pc_t'(1);
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
(
    input  byte_t    op,
    input  logic     wide_page,
    output op_kind_e kind
);
    always_comb begin
        kind = OK_STEP;
        if (op == OP_JID) begin
            kind = OK_JID;
        end else if (op == OP_RET) begin
            kind = OK_RET;
        end else if (op == OP_RETSK) begin
            kind = OK_RETSK;
        end else if (op[7:1] == 7'b0110_000) begin
            kind = OK_PFX_JMP;
        end else if (op[7:1] == 7'b0110_100) begin
            kind = OK_PFX_CALL;
        end else if (is_two_byte(op)) begin
            kind = OK_PFX_OTHER;
        end else if (op == OP_LQ) begin
            kind = OK_STEP;
        end else if (op[7]) begin
            if (wide_page)  kind = OK_JP_WIDE;
            else if (op[6]) kind = OK_JP_PAGE;
            else            kind = OK_JSRP;
        end
    end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top,
    output logic [W-1:0] low
);
    always_ff @(posedge clk) begin
        if (rst) begin
            top <= '0;
            low <= '0;
        end else if (push) begin
            low <= top;
            top <= push_val;
        end else if (pop) begin
            top <= low;
        end
    end
endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
    import pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       instr,
    input  logic [3:0]       acc,
    input  logic [3:0]       mnib,
    output logic [8:0]       fetch_addr,
    output logic             skip_active
);
    seq_st_e  state_q, state_d;
    pc_t      pc_q, pc_d, pc_next1;
    pend_t    pend_q, pend_d;
    byte_t    lk_q, lk_d;
    logic     skip_q, skip_d;
    logic     push, pop;
    pc_t      push_val;
    pc_t      sa, sb;
    op_kind_e kind;
    logic     in_fetch;

    pcs_decode u_dec (
        .op        (instr),
        .wide_page (page_is_wide(pc_q)),
        .kind      (kind)
    );

    pcs_stack #(.W(PC_W)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top      (sa),
        .low      (sb)
    );

    assign pc_next1 = inc9(pc_q);
    assign in_fetch = (state_q == ST_FETCH);

    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        pend_d   = pend_q;
        lk_d     = lk_q;
        skip_d   = skip_q;
        push     = 1'b0;
        pop      = 1'b0;
        push_val = pc_next1;
        unique case (state_q)
            ST_FETCH: begin
                if (skip_q) begin
                    pc_d = pc_next1;
                    if (is_two_byte(instr)) begin
                        state_d     = ST_OPER;
                        pend_d.kind = LK_NONE;
                        pend_d.hi   = 1'b0;
                    end else begin
                        skip_d = 1'b0;
                    end
                end else begin
                    unique case (kind)
                        OK_PFX_JMP, OK_PFX_CALL, OK_PFX_OTHER: begin
                            pc_d        = pc_next1;
                            state_d     = ST_OPER;
                            pend_d.hi   = instr[0];
                            pend_d.kind = (kind == OK_PFX_JMP)  ? LK_JUMP :
                                          (kind == OK_PFX_CALL) ? LK_CALL : LK_NONE;
                        end
                        OK_RET: begin
                            pc_d = sa;
                            pop  = 1'b1;
                        end
                        OK_RETSK: begin
                            pc_d   = sa;
                            pop    = 1'b1;
                            skip_d = 1'b1;
                        end
                        OK_JID: begin
                            state_d = ST_LOOKUP;
                            lk_d    = {acc, mnib};
                        end
                        OK_JP_WIDE: pc_d = {pc_q[8:7], instr[6:0]};
                        OK_JP_PAGE: pc_d = {pc_q[8:6], instr[5:0]};
                        OK_JSRP: begin
                            push = 1'b1;
                            pc_d = {CALL_PAGE, instr[5:0]};
                        end
                        default: pc_d = pc_next1;
                    endcase
                end
            end
            ST_OPER: begin
                state_d = ST_FETCH;
                if (skip_q) begin
                    pc_d   = pc_next1;
                    skip_d = 1'b0;
                end else begin
                    unique case (pend_q.kind)
                        LK_JUMP: pc_d = {pend_q.hi, instr};
                        LK_CALL: begin
                            push = 1'b1;
                            pc_d = {pend_q.hi, instr};
                        end
                        default: pc_d = pc_next1;
                    endcase
                end
            end
            ST_LOOKUP: begin
                state_d = ST_FETCH;
                pc_d    = {pc_q[8], instr};
            end
            default: state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            pend_q  <= '{kind: LK_NONE, hi: 1'b0};
            lk_q    <= '0;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            pend_q  <= pend_d;
            lk_q    <= lk_d;
            skip_q  <= skip_d;
        end
    end

    assign fetch_addr  = (state_q == ST_LOOKUP) ? {pc_q[8], lk_q} : pc_q;
    assign skip_active = skip_q;

endmodule

// File: rtl/pcs_sequencer_chk.sv
module pcs_sequencer_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] instr,
    input logic [3:0] acc,
    input logic [3:0] mnib,
    input logic [8:0] fetch_addr,
    input logic       skip_active,
    input logic       in_fetch,
    input logic [8:0] sa,
    input logic [8:0] sb
);
    logic live;
    logic two_b;
    logic wide;

    assign live  = in_fetch && !skip_active;
    assign two_b = (instr == 8'h23) || (instr == 8'h33) || (instr[7:4] == 4'h6);
    assign wide  = (fetch_addr[8:7] == 2'b01);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (fetch_addr == 9'h000) && !skip_active && (sa == 9'h000) && (sb == 9'h000));

    a_r7_ret_target: assert property (@(posedge clk) disable iff (rst)
        (live && instr == 8'h48) |=> fetch_addr == $past(sa));

    a_r7_ret_pop: assert property (@(posedge clk) disable iff (rst)
        (live && instr == 8'h48) |=> sa == $past(sb));

    a_r8_retsk_marks: assert property (@(posedge clk) disable iff (rst)
        (live && instr == 8'h49) |=> skip_active && fetch_addr == $past(sa));

    a_r9_lookup_addr: assert property (@(posedge clk) disable iff (rst)
        (live && instr == 8'hFF) |=> fetch_addr == {$past(fetch_addr[8]), $past(acc), $past(mnib)});

    a_r5_short_call: assert property (@(posedge clk) disable iff (rst)
        (live && !wide && instr[7:6] == 2'b10 && instr != 8'hBF)
        |=> (sa == $past(fetch_addr) + 9'd1) && (fetch_addr == {3'b010, $past(instr[5:0])}));

    a_r10_skip_one: assert property (@(posedge clk) disable iff (rst)
        (in_fetch && skip_active && !two_b)
        |=> !skip_active && (fetch_addr == $past(fetch_addr) + 9'd1));

    a_r10_skip_stack: assert property (@(posedge clk) disable iff (rst)
        (in_fetch && skip_active) |=> $stable(sa) && $stable(sb));
endmodule

bind pcs_sequencer pcs_sequencer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr       (instr),
    .acc         (acc),
    .mnib        (mnib),
    .fetch_addr  (fetch_addr),
    .skip_active (skip_active),
    .in_fetch    (in_fetch),
    .sa          (sa),
    .sb          (sb)
);

// File: tb/pcs_sequencer_tb.sv
module pcs_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] instr = 8'h00;
    logic [3:0] acc = 4'h0;
    logic [3:0] mnib = 4'h0;
    logic [8:0] fetch_addr;
    logic       skip_active;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pcs_sequencer u_dut (
        .clk         (clk),
        .rst         (rst),
        .instr       (instr),
        .acc         (acc),
        .mnib        (mnib),
        .fetch_addr  (fetch_addr),
        .skip_active (skip_active)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] b);
        instr = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic go(input logic [8:0] a);
        cyc({7'b0110_000, a[8]});
        cyc(a[7:0]);
    endtask

    function automatic logic [8:0] model_next(input logic [8:0] pc, input logic [7:0] op,
                                              output bit is_call, output string tag);
        bit w;
        w = (pc[8:7] == 2'b01);
        is_call = 0;
        tag = "R11 step";
        if (op >= 8'h80 && op != 8'hBF) begin
            if (w) begin
                tag = "R3 wide jump";
                return {pc[8:7], op[6:0]};
            end else if (op >= 8'hC0) begin
                tag = "R4 page jump";
                return {pc[8:6], op[5:0]};
            end else begin
                tag = "R5 short call";
                is_call = 1;
                return {3'b010, op[5:0]};
            end
        end
        return pc + 9'd1;
    endfunction

    function automatic bit excluded(input logic [7:0] op);
        return op == 8'h23 || op == 8'h33 || op[7:4] == 4'h6 ||
               op == 8'h48 || op == 8'h49 || op == 8'hFF;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, and stack entries read back through returns
        chk("R1 addr", fetch_addr, 9'h000);
        chk("R1 skip", {8'h00, skip_active}, 9'h000);
        go(9'h155);
        cyc(8'h48);
        chk("R1 top entry", fetch_addr, 9'h000);
        go(9'h155);
        cyc(8'h48);
        chk("R1 low entry", fetch_addr, 9'h000);

        // R3 R4 R5 R11 sweep over every page and every plain opcode
        for (int pg = 0; pg < 8; pg++) begin
            for (int op = 0; op < 256; op++) begin
                logic [8:0] base;
                logic [8:0] exp;
                bit         is_call;
                string      tag;
                if (excluded(8'(op))) continue;
                base = {3'(pg), 6'(pg * 7 + 3)};
                acc  = 4'(op);
                mnib = 4'(pg);
                go(base);
                chk("R2 long jump", fetch_addr, base);
                exp = model_next(base, 8'(op), is_call, tag);
                cyc(8'(op));
                chk(tag, fetch_addr, exp);
                if (is_call) begin
                    cyc(8'h48);
                    chk("R5 return addr", fetch_addr, base + 9'd1);
                end
            end
        end

        // R11 wrap
        go(9'h1FF);
        cyc(8'h00);
        chk("R11 wrap", fetch_addr, 9'h000);

        // R6 long call, R7 two-level stack
        do_reset();
        go(9'h100);
        cyc(8'h69);
        cyc(8'h23);
        chk("R6 long call target", fetch_addr, 9'h123);
        cyc(8'h85);
        chk("R5 nested call", fetch_addr, 9'h085);
        cyc(8'h48);
        chk("R7 first return", fetch_addr, 9'h124);
        cyc(8'h48);
        chk("R7 second return", fetch_addr, 9'h102);
        cyc(8'h48);
        chk("R7 low entry kept", fetch_addr, 9'h102);

        // R8 R10: skip of a single-byte jump
        do_reset();
        go(9'h150);
        cyc(8'h88);
        cyc(8'h49);
        chk("R8 return addr", fetch_addr, 9'h151);
        chk("R8 skip flag", {8'h00, skip_active}, 9'h001);
        cyc(8'hC0);
        chk("R10 skipped jump", fetch_addr, 9'h152);
        chk("R10 skip cleared", {8'h00, skip_active}, 9'h000);

        // R10: skip of a two-byte instruction, R12 second byte ignored
        do_reset();
        go(9'h150);
        cyc(8'h88);
        cyc(8'h49);
        cyc(8'h61);
        chk("R10 skip first byte", fetch_addr, 9'h152);
        chk("R10 skip held", {8'h00, skip_active}, 9'h001);
        cyc(8'h48);
        chk("R10 skip second byte", fetch_addr, 9'h153);
        chk("R10 skip done", {8'h00, skip_active}, 9'h000);

        // R10: skipped call leaves the stack alone
        do_reset();
        go(9'h150);
        cyc(8'h88);
        cyc(8'h49);
        cyc(8'h80);
        chk("R10 skipped call addr", fetch_addr, 9'h152);
        cyc(8'h48);
        chk("R10 skipped call no push", fetch_addr, 9'h000);

        // R12: second byte equal to the return opcode
        do_reset();
        go(9'h040);
        cyc(8'h33);
        cyc(8'h48);
        chk("R12 second byte", fetch_addr, 9'h042);

        // R9 table jump, upper and lower half
        go(9'h1A0);
        acc  = 4'h5;
        mnib = 4'hC;
        cyc(8'hFF);
        chk("R9 lookup addr hi", fetch_addr, 9'h15C);
        cyc(8'h37);
        chk("R9 target hi", fetch_addr, 9'h137);
        go(9'h0A0);
        acc  = 4'hF;
        mnib = 4'h0;
        cyc(8'hFF);
        chk("R9 lookup addr lo", fetch_addr, 9'h0F0);
        cyc(8'h48);
        chk("R9 byte not decoded", fetch_addr, 9'h048);

        done = 1;
        summary();
    end
endmodule